// File: doc/BRIEF.md
# Video Input Capture with Timing-Code Decode

This block sits at the edge of a video front end, clocked by the video sampling clock (27 or 54 MHz). It watches a 10-bit interleaved luma/chroma stream for embedded timing reference codes. These codes tell it where each line's active picture starts and ends, which field is current, and whether the line lies in vertical blanking. Inside the active region it hands each picture word onward, tagged with its component and its horizontal position.

An enable strobe qualifies every clock edge. External downsampling logic can hold the strobe low to skip edges, and so thin out capture without a nonstandard clock. On a skipped edge the block does nothing at all: it takes no sample, its position does not move, and its code search does not advance. The component order of the stream is chosen at run time from two interleavings. An 8-bit source drives the upper eight bits and ties the two lowest bits low. Code recognition looks only at those upper eight bits, so both source widths are handled alike.

Top module: `vid_capture`

## Requirements
- R1: While rst_n is low and after its release, smp_valid, smp_data, smp_kind, smp_hpos, active, field and vblank are all zero.
- R2: A rising edge with vin_en low has no effect. smp_valid stays low, smp_hpos, active, field and vblank keep their values, and vin_data on that edge is ignored, even when it looks like part of a timing code.
- R3: A timing code is three words whose upper eight bits are FF, 00, 00, followed by a flag word whose bits [9:6] are 1, F, V, H. Only bits [9:2] of each word are compared, so the low-tied words 3FC, 000, 000 from an 8-bit source are recognised as well.
- R4: A code with H=0 (start of line) loads field with F and vblank with V, and sets active to the inverse of V. A code with H=1 (end of line) clears active. Each of these outputs changes one clock after the flag word is taken.
- R5: While active is high, each enabled word that is not part of a timing code appears on smp_data one clock later, with smp_valid high for that single cycle. Preamble words and flag words are never emitted.
- R6: smp_hpos is 0 for the first sample after each start-of-line code and rises by one for each sample emitted after that. It holds its value between samples.
- R7: smp_kind encodes Y as 0, Cb as 1 and Cr as 2, and never takes the value 3. With order_sel=0 the sequence from the first sample of a line is Cb, Y, Cr, Y, repeating. With order_sel=1 it is Y, Cb, Y, Cr, repeating.
- R8: Any number of disabled edges may fall between the words of a timing code without stopping it from being recognised.
- R9: No sample is emitted before the first start-of-line code, after an end-of-line code, or on a line whose start code has V=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video sampling clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| order_sel | input | 1 | Component interleave: 0 = Cb,Y,Cr,Y; 1 = Y,Cb,Y,Cr |
| vin_en | input | 1 | Qualifies the current edge; low means the edge is skipped |
| vin_data | input | DATA_W | Video word; 8-bit sources use [9:2] with [1:0] low |
| smp_valid | output | 1 | One-cycle strobe marking a captured picture word |
| smp_data | output | DATA_W | Captured picture word |
| smp_kind | output | 2 | Component of the captured word: 0 Y, 1 Cb, 2 Cr |
| smp_hpos | output | POS_W | Horizontal position of the captured word |
| active | output | 1 | Inside the active part of a non-blanked line |
| field | output | 1 | F flag of the latest start-of-line code |
| vblank | output | 1 | V flag of the latest start-of-line code |

## Verification
The bench builds the block with its default widths: 10-bit data and an 11-bit position. It uses short lines of nine samples, so a line wraps past the four-phase component cycle more than twice. A nested sweep covers both interleave orders, both field values, blanked and unblanked lines, 10-bit and low-tied 8-bit words, and enable gaps of zero, one and two edges. The gap edges carry a preamble-like value. With these settings every component phase, every flag combination and the skipped-edge behaviour can all be reached inside a few thousand cycles.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
   typedef enum logic [1:0] {
      KIND_Y  = 2'd0,
      KIND_CB = 2'd1,
      KIND_CR = 2'd2
   } comp_kind_e;

   typedef struct packed {
      logic f;
      logic v;
      logic h;
   } trs_flags_t;

   localparam int TRS_CMP_W = 8;
endpackage

// File: rtl/vcap_trs_detect.sv
module vcap_trs_detect
   import vcap_pkg::*;
#(
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [DATA_W-1:0] word,
   output logic              code_hit,
   output logic              in_code,
   output trs_flags_t        flags
);
   localparam int TOP_LSB = DATA_W - TRS_CMP_W;

   logic [1:0]           st_q, st_d;
   logic [TRS_CMP_W-1:0] top;
   logic                 top_ones, top_zero;

   assign top      = word[DATA_W-1:TOP_LSB];
   assign top_ones = &top;
   assign top_zero = ~|top;

   always_comb begin
      st_d = st_q;
      if (en) begin
         unique case (st_q)
            2'd1, 2'd2: st_d = top_zero ? st_q + 2'd1 : (top_ones ? 2'd1 : 2'd0);
            default:    st_d = top_ones ? 2'd1 : 2'd0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= 2'd0;
      else        st_q <= st_d;
   end

   assign code_hit = en && (st_q == 2'd3);
   assign in_code  = top_ones || (st_q == 2'd3) ||
                     (top_zero && (st_q == 2'd1 || st_q == 2'd2));
   assign flags.f  = word[DATA_W-2];
   assign flags.v  = word[DATA_W-3];
   assign flags.h  = word[DATA_W-4];
endmodule

// File: rtl/vcap_pos_count.sv
module vcap_pos_count #(
   parameter int POS_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [POS_W-1:0] pos
);
   always_ff @(posedge clk) begin
      if (!rst_n)   pos <= '0;
      else if (clr) pos <= '0;
      else if (inc) pos <= pos + 1'b1;
   end
endmodule

// File: rtl/vcap_comp_map.sv
module vcap_comp_map
   import vcap_pkg::*;
(
   input  logic       order_sel,
   input  logic [1:0] phase,
   output comp_kind_e kind
);
   logic [1:0] eff;

   // Y-first order is the chroma-first order shifted by one phase
   assign eff = order_sel ? phase + 2'd3 : phase;

   always_comb begin
      unique case (eff)
         2'd0:    kind = KIND_CB;
         2'd2:    kind = KIND_CR;
         default: kind = KIND_Y;
      endcase
   end
endmodule

// File: rtl/vid_capture.sv
module vid_capture
   import vcap_pkg::*;
#(
   parameter int DATA_W = 10,
   parameter int POS_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              order_sel,
   input  logic              vin_en,
   input  logic [DATA_W-1:0] vin_data,
   output logic              smp_valid,
   output logic [DATA_W-1:0] smp_data,
   output logic [1:0]        smp_kind,
   output logic [POS_W-1:0]  smp_hpos,
   output logic              active,
   output logic              field,
   output logic              vblank
);
   generate
      if (DATA_W < TRS_CMP_W + 2) begin : g_bad_width
         $error("vid_capture: DATA_W must be at least 10");
      end
      if (POS_W < 2) begin : g_bad_pos
         $error("vid_capture: POS_W must be at least 2");
      end
   endgenerate

   logic              code_hit, in_code, emit;
   trs_flags_t        flags;
   logic [POS_W-1:0]  pos;
   comp_kind_e        kind;

   vcap_trs_detect #(.DATA_W(DATA_W)) u_det (
      .clk(clk), .rst_n(rst_n), .en(vin_en), .word(vin_data),
      .code_hit(code_hit), .in_code(in_code), .flags(flags)
   );

   assign emit = vin_en && active && !in_code;

   vcap_pos_count #(.POS_W(POS_W)) u_pos (
      .clk(clk), .rst_n(rst_n),
      .clr(code_hit && !flags.h), .inc(emit), .pos(pos)
   );

   vcap_comp_map u_map (
      .order_sel(order_sel), .phase(pos[1:0]), .kind(kind)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         field  <= 1'b0;
         vblank <= 1'b0;
      end else if (code_hit) begin
         if (!flags.h) begin
            field  <= flags.f;
            vblank <= flags.v;
            active <= !flags.v;
         end else begin
            active <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         smp_valid <= 1'b0;
         smp_data  <= '0;
         smp_kind  <= 2'd0;
         smp_hpos  <= '0;
      end else begin
         smp_valid <= emit;
         if (emit) begin
            smp_data <= vin_data;
            smp_kind <= kind;
            smp_hpos <= pos;
         end
      end
   end
endmodule

// File: rtl/vcap_checker.sv
module vcap_checker #(
   parameter int DATA_W = 10,
   parameter int POS_W  = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vin_en,
   input logic              smp_valid,
   input logic [DATA_W-1:0] smp_data,
   input logic [1:0]        smp_kind,
   input logic [POS_W-1:0]  smp_hpos,
   input logic              active,
   input logic              field,
   input logic              vblank
);
   assert_skip_no_sample_R2: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> $past(vin_en));

   assert_skip_holds_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(vin_en) |-> ($stable(smp_hpos) && $stable(active) &&
                          $stable(field) && $stable(vblank)));

   assert_no_code_emitted_R5: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> (smp_data[DATA_W-1 -: 8] != 8'hFF));

   assert_kind_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> (smp_kind != 2'd3));

   assert_sample_in_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |-> (active && !vblank));

   assert_blank_not_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
      vblank |-> !active);
endmodule

bind vid_capture vcap_checker #(.DATA_W(DATA_W), .POS_W(POS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .vin_en(vin_en), .smp_valid(smp_valid),
   .smp_data(smp_data), .smp_kind(smp_kind), .smp_hpos(smp_hpos),
   .active(active), .field(field), .vblank(vblank)
);

// File: tb/sim_vid_capture.sv
module sim_vid_capture;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        order_sel = 1'b0;
   logic        vin_en = 1'b0;
   logic [9:0]  vin_data = '0;
   logic        smp_valid;
   logic [9:0]  smp_data;
   logic [1:0]  smp_kind;
   logic [10:0] smp_hpos;
   logic        active, field, vblank;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   int exp_pos, last_hpos, gap;
   bit exp_active, mode8;

   always #10 clk = ~clk;

   vid_capture u0 (
      .clk(clk), .rst_n(rst_n), .order_sel(order_sel), .vin_en(vin_en),
      .vin_data(vin_data), .smp_valid(smp_valid), .smp_data(smp_data),
      .smp_kind(smp_kind), .smp_hpos(smp_hpos), .active(active),
      .field(field), .vblank(vblank)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input logic [9:0] w, input bit en);
      @(negedge clk);
      vin_data = w;
      vin_en   = en;
      @(posedge clk);
      #5;
   endtask

   function automatic logic [9:0] xy(input bit f, input bit v, input bit h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
   endfunction

   function automatic int kind_of(input int p, input bit ord);
      if (!ord) return (p % 2 == 1) ? 0 : ((p % 4 == 0) ? 1 : 2);
      return (p % 2 == 0) ? 0 : ((p % 4 == 1) ? 1 : 2);
   endfunction

   function automatic logic [9:0] pic(input int k);
      if (mode8) return 10'((4 + (k * 13) % 240) << 2);
      return 10'(4 + (k * 37) % 1000);
   endfunction

   task automatic put(input logic [9:0] w, input bit is_smp);
      for (int g = 0; g < gap; g++) begin
         step(mode8 ? 10'h3FC : 10'h3FF, 1'b0);
         chk(!smp_valid, "R2 skipped edge valid", smp_valid, 0);
         chk(smp_hpos == 11'(last_hpos), "R2 skipped edge hpos", smp_hpos, last_hpos);
      end
      step(w, 1'b1);
      if (is_smp && exp_active) begin
         chk(smp_valid, "R5 valid", smp_valid, 1);
         chk(smp_data == w, "R5 data", smp_data, w);
         chk(smp_hpos == 11'(exp_pos), "R6 hpos", smp_hpos, exp_pos);
         chk(int'(smp_kind) == kind_of(exp_pos, order_sel), "R7 kind",
             smp_kind, kind_of(exp_pos, order_sel));
         last_hpos = exp_pos;
         exp_pos++;
      end else begin
         chk(!smp_valid, "R9 R5 no sample", smp_valid, 0);
      end
   endtask

   task automatic code(input bit f, input bit v, input bit h);
      put(mode8 ? 10'h3FC : 10'h3FF, 1'b0);
      put(10'h000, 1'b0);
      put(10'h000, 1'b0);
      put(xy(f, v, h), 1'b0);
   endtask

   initial begin : watchdog
      #(150000 * 20);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : main
      exp_pos = 0; last_hpos = 0; gap = 0; exp_active = 0; mode8 = 0;
      repeat (3) @(posedge clk);
      #5;
      chk(!smp_valid && smp_hpos == 0 && smp_data == 0, "R1 reset outputs", smp_hpos, 0);
      chk(!active && !field && !vblank && smp_kind == 0, "R1 reset flags", active, 0);
      @(negedge clk);
      rst_n = 1'b1;
      // Picture-like words before any start code are dropped (R9)
      for (int k = 0; k < 4; k++) put(pic(k), 1'b1);
      // A broken preamble must not start a line (R3)
      put(10'h3FF, 1'b0); put(10'h000, 1'b0); put(10'h200, 1'b0);
      chk(!active, "R3 broken preamble", active, 0);

      for (int m = 0; m < 2; m++)
      for (int o = 0; o < 2; o++)
      for (int g = 0; g < 3; g++)
      for (int f = 0; f < 2; f++)
      for (int v = 0; v < 2; v++) begin
         mode8 = bit'(m);
         order_sel = bit'(o);
         gap = g;
         code(bit'(f), bit'(v), 1'b0);
         exp_active = !bit'(v);
         exp_pos = 0;
         chk(active == exp_active, "R4 R8 R3 start active", active, exp_active);
         chk(field == bit'(f), "R4 field", field, f);
         chk(vblank == bit'(v), "R4 vblank", vblank, v);
         for (int k = 0; k < 9; k++) put(pic(k + f * 3 + g), 1'b1);
         code(bit'(f), bit'(v), 1'b1);
         exp_active = 1'b0;
         chk(!active, "R4 end clears active", active, 0);
         chk(field == bit'(f) && vblank == bit'(v), "R4 end keeps flags", field, f);
         for (int k = 0; k < 2; k++) put(pic(k), 1'b1);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule